// File: doc/BRIEF.md
# Dual Interval Timer with Auxiliary Register Access

This block holds two identical 32-bit interval timers that software reaches through a private auxiliary register space. That space is separate from memory and is driven by a read strobe, a write strobe, an address and 32-bit write data. Each timer has three registers: a running count, a control word and a limit. The count climbs by one in every qualifying clock cycle. In the cycle after it equals the limit it returns to zero and keeps going, with no help from software. The two timers behave the same way and differ only in which interrupt line they drive: timer 0 feeds the line wired to interrupt 16 and timer 1 the line wired to interrupt 17.

The block runs on a clock that keeps running while the processor sleeps, so a pending timer interrupt can wake the core. Each timer can be told to count only in cycles when the processor is not halted. It can also be told to request a system reset when it wraps, which makes it usable as a watchdog. A read-only configuration word at address 0x75 tells software which timers are present.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every count and control register reads 0, every limit reads 0xFFFFFFFF, and `irq_t0`, `irq_t1` and `rst_req` are low.
- R2: Timer 0 has its count at 0x21, control at 0x22 and limit at 0x23. Timer 1 has the same three registers at 0x100, 0x101 and 0x102. `aux_rdata` carries the addressed register in the same cycle `aux_rd` is high, and it is 0 when `aux_rd` is low or the address is unmapped.
- R3: The count increases by one in every qualifying cycle. In a qualifying cycle where the count equals the limit, the next count is 0.
- R4: When control bit 1 is set, the count holds its value in every cycle where `halted` is high.
- R5: Control bit 3 is a pending flag. It is set by a wrap and cleared by a control write with bit 3 at 0. A control write with bit 3 at 1 leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the wrap wins. Control bits 31:4 always read 0.
- R6: `irq_t0` equals timer 0's pending bit AND its control bit 0. `irq_t1` is formed the same way from timer 1's bits.
- R7: `rst_req` is high for the one cycle that follows a wrap of any timer whose control bit 2 was set when the wrap happened.
- R8: A count write takes effect at the next edge and overrides counting and wrapping in that cycle. A limit write leaves the count untouched.
- R9: Address 0x75 reads 0x00000304 with default parameters: bits 7:0 hold the version 0x04, bit 8 means timer 0 is present and bit 9 means timer 1 is present. Writes to this address are ignored.
- R10: The two timers are independent. An access to one timer never changes the other timer's registers or its interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halted | input | 1 | Processor halted indication |
| aux_rd | input | 1 | Auxiliary register read strobe |
| aux_wr | input | 1 | Auxiliary register write strobe |
| aux_addr | input | 32 | Auxiliary register address |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data, combinational |
| irq_t0 | output | 1 | Timer 0 interrupt request (line 16) |
| irq_t1 | output | 1 | Timer 1 interrupt request (line 17) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The directed passes use short limits so that wraps arrive within a few cycles. They tell apart wrapping at the limit from free counting (R3), halted cycles with the qualifier on and off (R4), and a flag-clearing write from a flag-preserving one (R5). A random phase then mixes reads, writes of small limits and counts, random control nibbles and random halt patterns across both timers. Here every read and every interrupt and reset output is compared, cycle by cycle, against a bench model built from the requirements. That phase catches crosstalk between the timers and ordering faults when a software write and a wrap fall in the same cycle.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  typedef struct packed {
    logic pend;
    logic wdog;
    logic nohalt;
    logic ie;
  } tmr_ctrl_t;

  localparam int unsigned OFS_CNT = 0;
  localparam int unsigned OFS_CTL = 1;
  localparam int unsigned OFS_LIM = 2;
endpackage

// File: rtl/tmr_addr_match.sv
module tmr_addr_match #(
  parameter int unsigned AW   = 32,
  parameter logic [31:0] BASE = 32'h21
) (
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          wr_cnt,
  output logic          wr_ctl,
  output logic          wr_lim,
  output logic [2:0]    rsel
);
  import tmr_pair_pkg::*;

  logic hit_cnt, hit_ctl, hit_lim;

  always_comb begin
    hit_cnt = (addr == AW'(BASE + OFS_CNT));
    hit_ctl = (addr == AW'(BASE + OFS_CTL));
    hit_lim = (addr == AW'(BASE + OFS_LIM));
    wr_cnt  = wr && hit_cnt;
    wr_ctl  = wr && hit_ctl;
    wr_lim  = wr && hit_lim;
    rsel    = rd ? {hit_lim, hit_ctl, hit_cnt} : 3'b000;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   halted,
  input  logic                   ld_cnt,
  input  logic                   ld_ctl,
  input  logic                   ld_lim,
  input  logic [CW-1:0]          wdata,
  output logic [CW-1:0]          cnt_o,
  output tmr_pair_pkg::tmr_ctrl_t ctl_o,
  output logic [CW-1:0]          lim_o,
  output logic                   irq_o,
  output logic                   rst_pulse_o
);
  import tmr_pair_pkg::*;

  logic [CW-1:0] cnt_q, lim_q;
  tmr_ctrl_t     ctl_q;
  logic          rst_q;
  logic          tick, at_lim, wrap;

  always_comb begin
    tick   = !(ctl_q.nohalt && halted);
    at_lim = (cnt_q == lim_q);
    wrap   = tick && at_lim && !ld_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_cnt) begin
      cnt_q <= wdata;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '1;
    end else if (ld_lim) begin
      lim_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= wrap && ctl_q.wdog;
      if (ld_ctl) begin
        ctl_q.ie     <= wdata[0];
        ctl_q.nohalt <= wdata[1];
        ctl_q.wdog   <= wdata[2];
      end
      if (wrap) begin
        ctl_q.pend <= 1'b1;
      end else if (ld_ctl && !wdata[3]) begin
        ctl_q.pend <= 1'b0;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign lim_o       = lim_q;
  assign ctl_o       = ctl_q;
  assign irq_o       = ctl_q.pend && ctl_q.ie;
  assign rst_pulse_o = rst_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_lim && !ld_cnt) |=> (cnt_q == '0)) else $error("wrap"); // R3
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.nohalt && halted && !ld_cnt) |=> $stable(cnt_q)) else $error("halt"); // R4
  AST_PEND_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_lim && !ld_cnt) |=> ctl_q.pend) else $error("pend"); // R5
  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> (cnt_q == $past(wdata))) else $error("load"); // R8
  AST_LIMIT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lim && !ld_cnt && !tick) |=> $stable(cnt_q)) else $error("limit"); // R8
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter logic [7:0]  VERSION    = 8'h04,
  parameter bit          T0_PRESENT = 1'b1,
  parameter bit          T1_PRESENT = 1'b1,
  parameter logic [31:0] T0_BASE    = 32'h21,
  parameter logic [31:0] T1_BASE    = 32'h100,
  parameter logic [31:0] CFG_ADDR   = 32'h75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halted,
  input  logic          aux_rd,
  input  logic          aux_wr,
  input  logic [AW-1:0] aux_addr,
  input  logic [DW-1:0] aux_wdata,
  output logic [DW-1:0] aux_rdata,
  output logic          irq_t0,
  output logic          irq_t1,
  output logic          rst_req
);
  import tmr_pair_pkg::*;

  localparam int unsigned NT = 2;
  localparam logic [NT-1:0] PRESENT = {T1_PRESENT, T0_PRESENT};
  localparam logic [NT*32-1:0] BASES = {T1_BASE, T0_BASE};
  localparam logic [DW-1:0] CFG_WORD = DW'({22'd0, T1_PRESENT, T0_PRESENT, VERSION});

  logic [DW-1:0] rd_part [NT];
  logic [NT-1:0] irq_v;
  logic [NT-1:0] rst_v;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    if (PRESENT[i]) begin : g_on
      logic          wr_cnt, wr_ctl, wr_lim;
      logic [2:0]    rsel;
      logic [DW-1:0] cnt, lim;
      tmr_ctrl_t     ctl;

      tmr_addr_match #(.AW(AW), .BASE(BASES[i*32 +: 32])) u_match (
        .rd(aux_rd), .wr(aux_wr), .addr(aux_addr),
        .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wr_lim(wr_lim), .rsel(rsel)
      );

      tmr_channel #(.CW(DW)) u_chan (
        .clk(clk), .rst_n(rst_n), .halted(halted),
        .ld_cnt(wr_cnt), .ld_ctl(wr_ctl), .ld_lim(wr_lim),
        .wdata(aux_wdata),
        .cnt_o(cnt), .ctl_o(ctl), .lim_o(lim),
        .irq_o(irq_v[i]), .rst_pulse_o(rst_v[i])
      );

      always_comb begin
        rd_part[i] = '0;
        if (rsel[OFS_CNT]) rd_part[i] = cnt;
        if (rsel[OFS_CTL]) rd_part[i] = DW'(ctl);
        if (rsel[OFS_LIM]) rd_part[i] = lim;
      end
    end else begin : g_off
      assign rd_part[i] = '0;
      assign irq_v[i]   = 1'b0;
      assign rst_v[i]   = 1'b0;
    end
  end

  always_comb begin
    aux_rdata = '0;
    if (aux_rd && aux_addr == AW'(CFG_ADDR)) aux_rdata = CFG_WORD;
    for (int k = 0; k < NT; k++) aux_rdata = aux_rdata | rd_part[k];
  end

  assign irq_t0  = irq_v[0];
  assign irq_t1  = irq_v[1];
  assign rst_req = |rst_v;

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_rd |-> (aux_rdata == '0)) else $error("rdata"); // R2
  AST_CFG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_rd && aux_addr == AW'(CFG_ADDR)) |-> (aux_rdata == CFG_WORD)) else $error("cfg"); // R9
endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halted = 1'b0;
  logic        aux_rd = 1'b0;
  logic        aux_wr = 1'b0;
  logic [31:0] aux_addr = '0;
  logic [31:0] aux_wdata = '0;
  logic [31:0] aux_rdata;
  logic        irq_t0, irq_t1, rst_req;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [31:0] A_CFG = 32'h75;
  localparam logic [31:0] BASE0 = 32'h21;
  localparam logic [31:0] BASE1 = 32'h100;

  always #10 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .halted(halted),
    .aux_rd(aux_rd), .aux_wr(aux_wr), .aux_addr(aux_addr),
    .aux_wdata(aux_wdata), .aux_rdata(aux_rdata),
    .irq_t0(irq_t0), .irq_t1(irq_t1), .rst_req(rst_req)
  );

  // reference model built from the requirements
  logic [31:0] m_cnt [2];
  logic [31:0] m_lim [2];
  logic [3:0]  m_ctl [2];
  logic        m_rst;

  function automatic logic [31:0] base_of(int i);
    return (i == 0) ? BASE0 : BASE1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = '0; m_lim[i] = '1; m_ctl[i] = '0;
      end
      m_rst = 1'b0;
    end else begin
      logic rst_n_next;
      rst_n_next = 1'b0;
      for (int i = 0; i < 2; i++) begin
        logic wc, wt, wl, tick, wrap;
        wc   = aux_wr && aux_addr == base_of(i);
        wt   = aux_wr && aux_addr == base_of(i) + 1;
        wl   = aux_wr && aux_addr == base_of(i) + 2;
        tick = !(m_ctl[i][1] && halted);
        wrap = tick && !wc && (m_cnt[i] == m_lim[i]);
        if (wrap && m_ctl[i][2]) rst_n_next = 1'b1;
        if (wc) m_cnt[i] = aux_wdata;
        else if (wrap) m_cnt[i] = '0;
        else if (tick) m_cnt[i] = m_cnt[i] + 1;
        if (wl) m_lim[i] = aux_wdata;
        if (wt) m_ctl[i][2:0] = aux_wdata[2:0];
        if (wrap) m_ctl[i][3] = 1'b1;
        else if (wt && !aux_wdata[3]) m_ctl[i][3] = 1'b0;
      end
      m_rst = rst_n_next;
    end
  end

  function automatic logic [31:0] exp_read(logic [31:0] a);
    if (a == A_CFG) return 32'h0000_0304;
    for (int i = 0; i < 2; i++) begin
      if (a == base_of(i))     return m_cnt[i];
      if (a == base_of(i) + 1) return {28'd0, m_ctl[i]};
      if (a == base_of(i) + 2) return m_lim[i];
    end
    return 32'd0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: check outputs, drive inputs, check read data
  task automatic step(bit rd, bit wr, logic [31:0] a, logic [31:0] d, bit h, string tag);
    @(negedge clk);
    check("R6 irq_t0", {31'd0, irq_t0}, {31'd0, m_ctl[0][3] & m_ctl[0][0]});
    check("R6 irq_t1", {31'd0, irq_t1}, {31'd0, m_ctl[1][3] & m_ctl[1][0]});
    check("R7 rst_req", {31'd0, rst_req}, {31'd0, m_rst});
    aux_rd = rd; aux_wr = wr; aux_addr = a; aux_wdata = d; halted = h;
    #2;
    if (rd) check(tag, aux_rdata, exp_read(a));
    else    check("R2 idle rdata", aux_rdata, 32'd0);
  endtask

  task automatic wr_reg(logic [31:0] a, logic [31:0] d, string tag);
    step(1'b0, 1'b1, a, d, 1'b0, tag);
  endtask

  task automatic rd_reg(logic [31:0] a, bit h, string tag);
    step(1'b1, 1'b0, a, 32'd0, h, tag);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 outputs in reset
    check("R1 irq_t0", {31'd0, irq_t0}, 32'd0);
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);
    rst_n = 1'b1;
    // R1 reset values with literal expectations (timers counting from 0)
    @(negedge clk);
    aux_rd = 1'b1; aux_addr = BASE0 + 2; #2;
    check("R1 limit0 reset", aux_rdata, 32'hFFFF_FFFF);
    aux_addr = BASE1 + 1; #2;
    check("R1 ctrl1 reset", aux_rdata, 32'd0);
    aux_addr = A_CFG; #2;
    check("R9 config word", aux_rdata, 32'h0000_0304);
    aux_addr = 32'h24; #2;
    check("R2 unmapped", aux_rdata, 32'd0);
    aux_rd = 1'b0;
    for (int k = 0; k < 3; k++) begin
      rd_reg(BASE0 + k, 1'b0, "R1 timer0 regs");
      rd_reg(BASE1 + k, 1'b0, "R1 timer1 regs");
    end
    rd_reg(32'h74, 1'b0, "R2 unmapped");
    rd_reg(32'h103, 1'b0, "R2 unmapped");
    // R9 write ignored
    wr_reg(A_CFG, 32'hFFFF_FFFF, "R9");
    rd_reg(A_CFG, 1'b0, "R9 after write");
    // R3 wrap at small limit
    wr_reg(BASE0 + 2, 32'd4, "R3");
    wr_reg(BASE0, 32'd0, "R3");
    wr_reg(BASE0 + 1, 32'd1, "R3");
    for (int k = 0; k < 12; k++) rd_reg(BASE0, 1'b0, "R3 count0 wrap");
    // R5 pending handling, high bits zero
    rd_reg(BASE0 + 1, 1'b0, "R5 pend set");
    wr_reg(BASE0 + 1, 32'hFFFF_FFF9, "R5 keep pend");
    rd_reg(BASE0 + 1, 1'b0, "R5 upper bits zero");
    wr_reg(BASE0 + 2, 32'hFFFF_FFFF, "R5");
    wr_reg(BASE0 + 1, 32'd1, "R5 clear pend");
    rd_reg(BASE0 + 1, 1'b0, "R5 pend cleared");
    // R4 halt qualifier on timer 1, then off
    wr_reg(BASE1 + 1, 32'd2, "R4");
    for (int k = 0; k < 6; k++) rd_reg(BASE1, 1'b1, "R4 halted hold");
    for (int k = 0; k < 3; k++) rd_reg(BASE1, 1'b0, "R4 resumes");
    wr_reg(BASE1 + 1, 32'd0, "R4");
    for (int k = 0; k < 3; k++) rd_reg(BASE1, 1'b1, "R4 qualifier off");
    // R7 reset request from timer 1
    wr_reg(BASE1 + 2, 32'd2, "R7");
    wr_reg(BASE1, 32'd0, "R7");
    wr_reg(BASE1 + 1, 32'd4, "R7");
    for (int k = 0; k < 10; k++) rd_reg(BASE1 + 1, 1'b0, "R7 watchdog run");
    // R8 limit write keeps count, count write loads
    wr_reg(BASE0, 32'd10, "R8");
    wr_reg(BASE0 + 2, 32'd100, "R8 limit write");
    rd_reg(BASE0, 1'b0, "R8 count kept");
    wr_reg(BASE0, 32'h77, "R8 load");
    rd_reg(BASE0, 1'b0, "R8 count loaded");
    // R10 random mix on both timers
    for (int n = 0; n < 3000; n++) begin
      int sel, op;
      logic [31:0] a, d;
      sel = int'($urandom_range(0, 8));
      op  = int'($urandom_range(0, 3));
      case (sel)
        6: a = A_CFG;
        7: a = 32'h23 + 32'($urandom_range(1, 3));
        8: a = 32'h0;
        default: a = ((sel < 3) ? BASE0 : BASE1) + 32'(sel % 3);
      endcase
      case (sel % 3)
        0: d = 32'($urandom_range(0, 60));
        1: d = 32'($urandom_range(0, 15));
        default: d = 32'($urandom_range(0, 40));
      endcase
      step(op == 0, op == 1, a, d, ($urandom_range(0, 9) < 3), "R10 random read");
    end
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule